// File: doc/BRIEF.md
# Dual-Channel Converter Command Receiver

This block is the digital front end of a two-channel 10-bit voltage converter. A host shifts a 16-bit command into it over a three-wire serial port made of an active-low chip select, a serial clock and a data line. The block samples all three wires with a fast system clock and decodes four control bits at the top of the word. It then moves the 10-bit code into one of three holding latches: the channel A output latch, the channel B output latch, or a staging latch. One command class writes channel A and, in the same cycle, copies the staging latch into channel B. A host can therefore preload B and then change both outputs together. The same word also sets a settling-speed flag and a power-down flag.

A parameter selects how a frame ends. In the plain variant, only the rising edge of chip select closes a frame. A frame closed with any bit count other than sixteen is dropped and flagged. In the counting variant, the block closes the frame by itself on the sixteenth serial clock fall. It then ignores the port until chip select falls again. An earlier chip-select rise also closes the frame.

Top module: `dacif_dual_front`

## Requirements
- R1: After reset, both output codes and the staging latch are zero, both mode flags are 0, and the update and frame-error pulses are low.
- R2: While chip select is low, one data bit is taken on each serial clock falling edge, most significant bit first. In the 16-bit word, bits 11..2 are the code (bit 11 is its MSB), and bits 1..0 have no effect on any output.
- R3: A completed word with bit 15 = 1 loads the code into channel A and copies the staging latch into channel B in the same cycle. The staging latch keeps its value.
- R4: A completed word with bit 15 = 0 and bit 12 = 0 loads the code into both channel B and the staging latch, and channel A keeps its value.
- R5: A completed word with bit 15 = 0 and bit 12 = 1 loads only the staging latch, and both output codes keep their values.
- R6: Every completed word sets the speed flag to bit 14 (1 = fast) and the power-down flag to bit 13 (1 = powered down).
- R7: In the plain variant, no output changes until chip select rises. The load becomes visible on the fourth system clock edge after the rise is first sampled.
- R8: In the counting variant, the sixteenth serial clock fall completes the word without a chip-select rise. Later clock falls and the closing chip-select rise in that frame have no effect.
- R9: In the counting variant, a chip-select rise after fewer than sixteen falls closes the frame. No latch or flag is loaded, and frame_error pulses for one cycle.
- R10: In the plain variant, a frame that closes with a bit count other than sixteen (fewer or more) loads nothing, and frame_error pulses for one cycle.
- R11: upd_a and upd_b each pulse for exactly one cycle when their output latch is loaded. They rise in the same cycle the new code appears, and they stay low otherwise.
- R12: Serial clock edges while chip select is high have no effect on any output or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| code_a | output | 10 | Channel A output latch |
| code_b | output | 10 | Channel B output latch |
| fast_mode | output | 1 | Speed selection from the last completed word |
| power_down | output | 1 | Power-down selection from the last completed word |
| upd_a | output | 1 | One-cycle pulse when channel A is loaded |
| upd_b | output | 1 | One-cycle pulse when channel B is loaded |
| frame_error | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The two functions that can fall in the same cycle are the load of channel A from the shifted word and the copy of the staging latch into channel B. The bench provokes this by first writing a staging-only word with a code different from channel B. It then sends an A-class word and later repeats the A-class word without a new staging write. A behavioural reference model runs next to both framing variants and compares code_a, code_b, upd_a and upd_b on every clock. A copy that lands one cycle apart from the A load, or a copy that also rewrites the staging latch, therefore shows up as a cycle mismatch.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   // Destination class of a completed command word
   typedef enum logic [1:0] {
      LD_A_COPY_B   = 2'd0,
      LD_B_AND_STG  = 2'd1,
      LD_STG_ONLY   = 2'd2
   } load_kind_t;

   function automatic load_kind_t classify(input logic sel_a, input logic stg_only);
      if (sel_a)
         return LD_A_COPY_B;
      else if (!stg_only)
         return LD_B_AND_STG;
      else
         return LD_STG_ONLY;
   endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int           W      = 1,
   parameter int           STAGES = 2,
   parameter logic [W-1:0] IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dacif_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= IDLE;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx #(
   parameter int WORD_W    = 16,
   parameter int FILL_W    = 2,
   parameter bit SELF_TERM = 1'b0,
   localparam int KEEP_W   = WORD_W - FILL_W,
   localparam int CNT_W    = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl,
   input  logic              sck_lvl,
   input  logic              din_lvl,
   output logic              frame_done,
   output logic              frame_bad,
   output logic [KEEP_W-1:0] frame_word
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

   generate
      if (FILL_W < 0 || FILL_W >= WORD_W) begin : g_bad_fill
         $error("dacif_frame_rx: FILL_W out of range");
      end
   endgenerate

   logic              prev_cs, prev_sck, active;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] sh;
   logic              count_ends;

   // Framing variant: self-terminating after WORD_W falls, or chip-select only
   generate
      if (SELF_TERM) begin : g_counting
         assign count_ends = 1'b1;
      end else begin : g_cs_only
         assign count_ends = 1'b0;
      end
   endgenerate

   wire cs_fall  = prev_cs & ~cs_lvl;
   wire cs_rise  = ~prev_cs & cs_lvl;
   wire sck_fall = prev_sck & ~sck_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs    <= 1'b1;
         prev_sck   <= 1'b0;
         active     <= 1'b0;
         cnt        <= '0;
         sh         <= '0;
         frame_done <= 1'b0;
         frame_bad  <= 1'b0;
      end else begin
         prev_cs    <= cs_lvl;
         prev_sck   <= sck_lvl;
         frame_done <= 1'b0;
         frame_bad  <= 1'b0;
         if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (active && cs_rise) begin
            active <= 1'b0;
            if (cnt == FULL) frame_done <= 1'b1;
            else             frame_bad  <= 1'b1;
         end else if (active && sck_fall && !cs_lvl) begin
            sh <= {sh[WORD_W-2:0], din_lvl};
            if (cnt != SAT) cnt <= cnt + 1'b1;
            if (count_ends && cnt == LAST) begin
               frame_done <= 1'b1;
               active     <= 1'b0;
            end
         end
      end
   end

   assign frame_word = sh[WORD_W-1:FILL_W];

   // R8
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SELF_TERM && active) |-> (cnt < FULL));
   // R10
   done_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done && frame_bad));

endmodule

// File: rtl/dacif_latch_bank.sv
module dacif_latch_bank
   import dacif_pkg::*;
#(
   parameter int CODE_W  = 10,
   localparam int KEEP_W = CODE_W + 4,
   localparam int B_SEL  = KEEP_W - 1,
   localparam int B_SPD  = KEEP_W - 2,
   localparam int B_PWD  = KEEP_W - 3,
   localparam int B_STG  = KEEP_W - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic              frame_bad,
   input  logic [KEEP_W-1:0] frame_word,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b,
   output logic              fast_mode,
   output logic              power_down,
   output logic              upd_a,
   output logic              upd_b,
   output logic              frame_error
);

   logic [CODE_W-1:0] stage_q;
   load_kind_t        kind;
   wire [CODE_W-1:0]  code_in = frame_word[CODE_W-1:0];

   assign kind = classify(frame_word[B_SEL], frame_word[B_STG]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_a      <= '0;
         code_b      <= '0;
         stage_q     <= '0;
         fast_mode   <= 1'b0;
         power_down  <= 1'b0;
         upd_a       <= 1'b0;
         upd_b       <= 1'b0;
         frame_error <= 1'b0;
      end else begin
         upd_a       <= 1'b0;
         upd_b       <= 1'b0;
         frame_error <= frame_bad;
         if (frame_done) begin
            fast_mode  <= frame_word[B_SPD];
            power_down <= frame_word[B_PWD];
            case (kind)
               LD_A_COPY_B: begin
                  code_a <= code_in;
                  code_b <= stage_q;
                  upd_a  <= 1'b1;
                  upd_b  <= 1'b1;
               end
               LD_B_AND_STG: begin
                  code_b  <= code_in;
                  stage_q <= code_in;
                  upd_b   <= 1'b1;
               end
               default: stage_q <= code_in;
            endcase
         end
      end
   end

   // R3
   copy_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_word[B_SEL]) |=> (code_b == $past(stage_q)) && $stable(stage_q));
   // R4
   b_mirrors_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_word[B_SEL] && !frame_word[B_STG]) |=> (code_b == stage_q) && $stable(code_a));
   // R5
   stage_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_word[B_SEL] && frame_word[B_STG]) |=> $stable(code_a) && $stable(code_b));
   // R11
   no_stray_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> !upd_a && !upd_b);

endmodule

// File: rtl/dacif_dual_front.sv
module dacif_dual_front #(
   parameter int CODE_W      = 10,
   parameter int FILL_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit SELF_TERM   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b,
   output logic              fast_mode,
   output logic              power_down,
   output logic              upd_a,
   output logic              upd_b,
   output logic              frame_error
);

   localparam int WORD_W = CODE_W + FILL_W + 4;
   localparam int KEEP_W = WORD_W - FILL_W;

   generate
      if (CODE_W < 1) begin : g_bad_code
         $error("dacif_dual_front: CODE_W must be positive");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              done, bad;
   logic [KEEP_W-1:0] word;

   dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdin}),
      .q     (pins_s)
   );

   dacif_frame_rx #(.WORD_W(WORD_W), .FILL_W(FILL_W), .SELF_TERM(SELF_TERM)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_lvl     (pins_s[2]),
      .sck_lvl    (pins_s[1]),
      .din_lvl    (pins_s[0]),
      .frame_done (done),
      .frame_bad  (bad),
      .frame_word (word)
   );

   dacif_latch_bank #(.CODE_W(CODE_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_done  (done),
      .frame_bad   (bad),
      .frame_word  (word),
      .code_a      (code_a),
      .code_b      (code_b),
      .fast_mode   (fast_mode),
      .power_down  (power_down),
      .upd_a       (upd_a),
      .upd_b       (upd_b),
      .frame_error (frame_error)
   );

endmodule

// File: tb/test_dacif_dual_front.sv
`timescale 1ns/1ps
module test_dacif_dual_front;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
   always #2 clk = ~clk;

   logic [9:0] a0, b0, a1, b1;
   logic f0, p0, ua0, ub0, e0, f1, p1, ua1, ub1, e1;

   dacif_dual_front #(.SELF_TERM(1'b0)) i_dacif_dual_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
      .code_a(a0), .code_b(b0), .fast_mode(f0), .power_down(p0),
      .upd_a(ua0), .upd_b(ub0), .frame_error(e0));

   dacif_dual_front #(.SELF_TERM(1'b1)) i_dacif_dual_front_cnt (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
      .code_a(a1), .code_b(b1), .fast_mode(f1), .power_down(p1),
      .upd_a(ua1), .upd_b(ub1), .frame_error(e1));

   int n_cmp = 0, n_bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic       h_cs[3], h_sk[3], h_dn[3];
   logic [9:0] m_a[2], m_b[2], m_st[2];
   logic       m_f[2], m_p[2], m_ua[2], m_ub[2], m_e[2];
   logic       m_act[2], m_pd[2], m_pb[2];
   int         m_cnt[2];
   logic [15:0] m_sh[2], m_pw[2];

   task automatic model_reset();
      for (int i = 0; i < 3; i++) begin h_cs[i] = 1'b1; h_sk[i] = 1'b0; h_dn[i] = 1'b0; end
      for (int k = 0; k < 2; k++) begin
         m_a[k] = '0; m_b[k] = '0; m_st[k] = '0; m_f[k] = 0; m_p[k] = 0;
         m_ua[k] = 0; m_ub[k] = 0; m_e[k] = 0; m_act[k] = 0; m_pd[k] = 0;
         m_pb[k] = 0; m_cnt[k] = 0; m_sh[k] = '0; m_pw[k] = '0;
      end
   endtask

   task automatic model_step(input int k);
      logic fall_cs, rise_cs, fall_sk;
      m_ua[k] = 0; m_ub[k] = 0; m_e[k] = m_pb[k];
      if (m_pd[k]) begin
         m_f[k] = m_pw[k][14];
         m_p[k] = m_pw[k][13];
         if (m_pw[k][15]) begin
            m_b[k] = m_st[k]; m_a[k] = m_pw[k][11:2]; m_ua[k] = 1; m_ub[k] = 1;
         end else if (!m_pw[k][12]) begin
            m_b[k] = m_pw[k][11:2]; m_st[k] = m_pw[k][11:2]; m_ub[k] = 1;
         end else begin
            m_st[k] = m_pw[k][11:2];
         end
      end
      m_pd[k] = 0; m_pb[k] = 0;
      fall_cs = h_cs[2] && !h_cs[1];
      rise_cs = !h_cs[2] && h_cs[1];
      fall_sk = h_sk[2] && !h_sk[1];
      if (fall_cs) begin
         m_act[k] = 1; m_cnt[k] = 0;
      end else if (m_act[k] && rise_cs) begin
         m_act[k] = 0;
         if (m_cnt[k] == 16) m_pd[k] = 1; else m_pb[k] = 1;
      end else if (m_act[k] && fall_sk && !h_cs[1]) begin
         m_sh[k] = {m_sh[k][14:0], h_dn[1]};
         if (k == 1 && m_cnt[k] == 15) begin m_pd[k] = 1; m_act[k] = 0; end
         if (m_cnt[k] < 17) m_cnt[k]++;
      end
      if (m_pd[k]) m_pw[k] = m_sh[k];
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         model_step(0);
         model_step(1);
         h_cs[2] = h_cs[1]; h_cs[1] = h_cs[0]; h_cs[0] = cs_n;
         h_sk[2] = h_sk[1]; h_sk[1] = h_sk[0]; h_sk[0] = sclk;
         h_dn[2] = h_dn[1]; h_dn[1] = h_dn[0]; h_dn[0] = sdin;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 code_a plain",   a0,  m_a[0]);
         chk("R4 code_b plain",   b0,  m_b[0]);
         chk("R6 fast plain",     f0,  m_f[0]);
         chk("R6 pwrdn plain",    p0,  m_p[0]);
         chk("R11 upd_a plain",   ua0, m_ua[0]);
         chk("R11 upd_b plain",   ub0, m_ub[0]);
         chk("R10 error plain",   e0,  m_e[0]);
         chk("R3 code_a count",   a1,  m_a[1]);
         chk("R4 code_b count",   b1,  m_b[1]);
         chk("R6 fast count",     f1,  m_f[1]);
         chk("R6 pwrdn count",    p1,  m_p[1]);
         chk("R11 upd_a count",   ua1, m_ua[1]);
         chk("R11 upd_b count",   ub1, m_ub[1]);
         chk("R9 error count",    e1,  m_e[1]);
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_open(input logic [15:0] w, input int nbits);
      cs_n = 1'b0; wait_n(3);
      for (int i = 0; i < nbits; i++) begin
         sdin = (i < 16) ? w[15-i] : 1'b0;
         sclk = 1'b1; wait_n(3);
         sclk = 1'b0; wait_n(3);
      end
   endtask

   task automatic frame_close();
      cs_n = 1'b1; wait_n(8);
   endtask

   task automatic send(input logic [15:0] w, input int nbits);
      frame_open(w, nbits);
      frame_close();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      // R1 reset state
      chk("R1 a", a0, 0); chk("R1 b", b0, 0); chk("R1 flags", {f0, p0, ua0, ub0, e0}, 0);
      chk("R1 count flags", {a1, b1, f1, p1, e1}, 0);

      // R2 / R4: B and staging, fill bits set to 1 must not matter
      send({4'b0000, 10'h2AB, 2'b11}, 16);
      chk("R2 msb-first code_b", b0, 10'h2AB);
      chk("R4 a kept", a0, 0);
      chk("R4 count b", b1, 10'h2AB);

      // R5 staging only
      send({4'b0001, 10'h155, 2'b00}, 16);
      chk("R5 b kept", b0, 10'h2AB);
      chk("R5 a kept", a0, 0);

      // R3 A write with simultaneous B copy, fast mode
      send({4'b1100, 10'h3FF, 2'b10}, 16);
      chk("R3 a", a0, 10'h3FF);
      chk("R3 b copied", b0, 10'h155);
      chk("R6 fast", f0, 1);

      // R3 repeated A write, staging unchanged; R6 power-down
      send({4'b1010, 10'h001, 2'b01}, 16);
      chk("R3 a again", a0, 10'h001);
      chk("R3 b from staging", b0, 10'h155);
      chk("R6 pwrdn", p0, 1);
      chk("R6 slow", f0, 0);

      // R9 / R10 short frame
      send({4'b0000, 10'h0AA, 2'b00}, 12);
      chk("R10 short dropped", b0, 10'h155);
      chk("R9 short dropped count", b1, 10'h155);

      // R8 / R10 long frame
      send({4'b0000, 10'h0F0, 2'b00}, 20);
      chk("R10 long dropped", b0, 10'h155);
      chk("R8 count loads first 16", b1, 10'h0F0);
      chk("R8 count pwrdn", p1, 0);

      // R12 clocks with chip select high
      sdin = 1'b1;
      for (int i = 0; i < 5; i++) begin sclk = 1'b1; wait_n(3); sclk = 1'b0; wait_n(3); end
      chk("R12 idle clocks plain", b0, 10'h155);
      send({4'b0100, 10'h07E, 2'b00}, 16);
      chk("R12 next frame plain", b0, 10'h07E);
      chk("R12 next frame count", b1, 10'h07E);
      chk("R6 fast count", f1, 1);

      // R7 load held back until chip select rises (plain variant)
      frame_open({4'b0000, 10'h2C3, 2'b00}, 16);
      wait_n(10);
      chk("R7 plain waits for rise", b0, 10'h07E);
      chk("R8 count already loaded", b1, 10'h2C3);
      frame_close();
      chk("R7 plain after rise", b0, 10'h2C3);

      wait_n(4);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule